// File: doc/BRIEF.md
# Lane Arithmetic and Logic Unit

This block is the arithmetic and logic unit of one execution lane in a small processor that issues a single instruction to several lanes in lockstep. Each cycle it takes a 4-bit operation code, two 32-bit operands and a 16-bit immediate. One clock edge later it presents a 32-bit result together with a zero flag and an overflow flag. Operand fetch, register storage and instruction decoding sit outside the block. The block's only state is its output register.

It supports sixteen operations:
- add and subtract
- the low word of a product
- unsigned quotient and remainder
- the bitwise family, including the inverted forms
- logical shifts
- two immediate forms

A zero divisor never leaves the result undefined. It returns all ones and raises the overflow flag.

Top module: `lane_alu`

## Requirements
- R1: Operation codes are 0x0 add, 0x1 subtract, 0x2 multiply, 0x3 divide, 0x4 and, 0x5 or, 0x6 xor, 0x7 not, 0x8 shift left, 0x9 shift right, 0xA nand, 0xB nor, 0xC xnor, 0xD modulo, 0xE add-immediate, 0xF move-immediate. Add and subtract wrap modulo 2^32.
- R2: Multiply returns the low 32 bits of the product of the two operands.
- R3: Divide returns the unsigned quotient of operand A by operand B. Modulo returns the unsigned remainder.
- R4: Divide or modulo with operand B equal to zero returns 0xFFFFFFFF and sets the overflow flag. In every other case the overflow flag is 0.
- R5: And, or, xor, nand, nor and xnor apply bitwise to both operands. The last three invert the results of the first three.
- R6: Not returns the inverse of operand A, and operand B has no effect on the result.
- R7: Shift left and shift right move operand A by operand B bits [4:0]. Both shifts fill with zeros. Bits [31:5] of operand B have no effect.
- R8: The immediate is zero-extended to 32 bits. Add-immediate returns operand A plus the immediate. Move-immediate returns the immediate alone.
- R9: The zero flag is 1 exactly when the 32-bit result is zero.
- R10: Result and flags are registered. They reflect the inputs present at the previous rising clock edge. A synchronous active-high reset sets the result to 0, the zero flag to 1 and the overflow flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| src_a_i | input | 32 | Operand A |
| src_b_i | input | 32 | Operand B |
| imm_i | input | 16 | Immediate value |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Result-is-zero flag |
| ovf_o | output | 1 | Zero-divisor flag |

## Verification
The result and both flags for an operation are due at the first rising edge after that operation's inputs are applied, with no further latency. The bench changes inputs on the falling edge and waits one rising edge. It then samples 1 ns later, so every check sees exactly the register loaded from the inputs under test. The reset values are checked the same way, one edge after reset is asserted.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOT  = 4'h7,
    OP_SHL  = 4'h8,
    OP_SHR  = 4'h9,
    OP_NAND = 4'hA,
    OP_NOR  = 4'hB,
    OP_XNOR = 4'hC,
    OP_MOD  = 4'hD,
    OP_ADDI = 4'hE,
    OP_MOVI = 4'hF
  } op_t;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_BITS  = 2'd1,
    GRP_DIV   = 2'd2
  } grp_t;

  function automatic grp_t op_group(input op_t op);
    case (op)
      OP_DIV, OP_MOD: return GRP_DIV;
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL, OP_SHR,
      OP_NAND, OP_NOR, OP_XNOR: return GRP_BITS;
      default: return GRP_ARITH;
    endcase
  endfunction
endpackage

// File: rtl/lane_alu_arith.sv
module lane_alu_arith
  import lane_alu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int IW = IMM_W
) (
  input  op_t            op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [IW-1:0]  imm_i,
  output logic [W-1:0]   res_o
);
  localparam int PAD_W = W - IW;

  logic [W-1:0] imm_ext;
  logic [W-1:0] mul_lo;

  assign imm_ext = {{PAD_W{1'b0}}, imm_i};
  assign mul_lo  = a_i * b_i;

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = mul_lo;
      OP_ADDI: res_o = a_i + imm_ext;
      OP_MOVI: res_o = imm_ext;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/lane_alu_bits.sv
module lane_alu_bits
  import lane_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  op_t          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] shamt;
  assign shamt = b_i[SH_W-1:0];

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      OP_SHL:  res_o = a_i << shamt;
      OP_SHR:  res_o = a_i >> shamt;
      OP_NAND: res_o = ~(a_i & b_i);
      OP_NOR:  res_o = ~(a_i | b_i);
      OP_XNOR: res_o = ~(a_i ^ b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/lane_alu_div.sv
module lane_alu_div
  import lane_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  op_t          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         zdiv_o
);
  logic         is_div_op;
  logic [W-1:0] quot;
  logic [W-1:0] rem;

  assign is_div_op = (op_i == OP_DIV) || (op_i == OP_MOD);
  assign zdiv_o    = is_div_op && (b_i == '0);

  always_comb begin
    quot = '1;
    rem  = '1;
    if (b_i != '0) begin
      quot = a_i / b_i;
      rem  = a_i % b_i;
    end
  end

  always_comb begin
    case (op_i)
      OP_DIV:  res_o = quot;
      OP_MOD:  res_o = rem;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o,
  output logic              ovf_o
);
  op_t               op;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] bits_res;
  logic [DATA_W-1:0] div_res;
  logic              zdiv;
  logic [DATA_W-1:0] res_next;

  assign op = op_t'(op_i);

  lane_alu_arith #(.W(DATA_W), .IW(IMM_W)) u_arith (
    .op_i(op), .a_i(src_a_i), .b_i(src_b_i), .imm_i(imm_i), .res_o(arith_res)
  );

  lane_alu_bits #(.W(DATA_W)) u_bits (
    .op_i(op), .a_i(src_a_i), .b_i(src_b_i), .res_o(bits_res)
  );

  lane_alu_div #(.W(DATA_W)) u_div (
    .op_i(op), .a_i(src_a_i), .b_i(src_b_i), .res_o(div_res), .zdiv_o(zdiv)
  );

  always_comb begin
    case (op_group(op))
      GRP_BITS: res_next = bits_res;
      GRP_DIV:  res_next = div_res;
      default:  res_next = arith_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      zero_o <= 1'b1;
      ovf_o  <= 1'b0;
    end else begin
      res_o  <= res_next;
      zero_o <= (res_next == '0);
      ovf_o  <= zdiv;
    end
  end
endmodule

// File: rtl/lane_alu_checker.sv
module lane_alu_checker
  import lane_alu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] res_o,
  input logic              zero_o,
  input logic              ovf_o
);
  logic div_like;
  assign div_like = (op_i == OP_DIV) || (op_i == OP_MOD);

  a_r1_add_wrap: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |=> (res_o == $past(src_a_i) + $past(src_b_i)));

  a_r4_zero_divisor: assert property (@(posedge clk) disable iff (rst)
    (div_like && src_b_i == '0) |=> (res_o == '1 && ovf_o));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !(div_like && src_b_i == '0) |=> !ovf_o);

  a_r6_not_a_only: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NOT) |=> (res_o == ~$past(src_a_i)));

  a_r8_move_imm: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_MOVI) |=> (res_o == {{(DATA_W-IMM_W){1'b0}}, $past(imm_i)}));

  a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0));

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (res_o == '0 && zero_o && !ovf_o));
endmodule

bind lane_alu lane_alu_checker u_lane_alu_checker (.*);

// File: tb/test_lane_alu.sv
`timescale 1ns/1ps
module test_lane_alu;
  import lane_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = 4'h0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] res_o;
  logic        zero_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_alu i_lane_alu (.*);

  // Reference model written from the requirements.
  function automatic logic [31:0] ref_res(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] imm);
    logic [31:0] ie;
    ie = {16'h0, imm};
    case (op)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return a * b;
      4'h3: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      4'h4: return a & b;
      4'h5: return a | b;
      4'h6: return a ^ b;
      4'h7: return ~a;
      4'h8: return a << b[4:0];
      4'h9: return a >> b[4:0];
      4'hA: return ~(a & b);
      4'hB: return ~(a | b);
      4'hC: return ~(a ^ b);
      4'hD: return (b == 0) ? 32'hFFFF_FFFF : a % b;
      4'hE: return a + ie;
      default: return ie;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Apply one operation and check the registered outputs one edge later.
  task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] imm,
                        input logic [31:0] exp);
    logic exp_ovf;
    @(negedge clk);
    op_i = op; src_a_i = a; src_b_i = b; imm_i = imm;
    @(posedge clk);
    #1;
    exp_ovf = ((op == 4'h3) || (op == 4'hD)) && (b == 0);
    check(req, res_o, exp);
    check({req, " ref"}, res_o, ref_res(op, a, b, imm));
    check("R9 zero flag", {31'd0, zero_o}, {31'd0, exp == 0});
    check("R4 overflow flag", {31'd0, ovf_o}, {31'd0, exp_ovf});
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; op_i = 4'h0; src_a_i = 32'd5; src_b_i = 32'd6;
    @(posedge clk);
    #1;
    check("R10 reset result", res_o, 32'h0);
    check("R10 reset zero", {31'd0, zero_o}, 32'd1);
    check("R10 reset ovf", {31'd0, ovf_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_addsub;
    run_op("R1 add", 4'h0, 32'd10, 32'd20, 16'h0, 32'd30);
    run_op("R1 add wrap", 4'h0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'h0);
    run_op("R1 sub", 4'h1, 32'd100, 32'd1, 16'h0, 32'd99);
    run_op("R1 sub wrap", 4'h1, 32'd0, 32'd1, 16'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_mul;
    run_op("R2 mul", 4'h2, 32'h1234_5678, 32'h10, 16'h0, 32'h2345_6780);
    run_op("R2 mul low zero", 4'h2, 32'h0001_0000, 32'h0001_0000, 16'h0, 32'h0);
    run_op("R2 mul large", 4'h2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'h1);
  endtask

  task automatic t_divmod;
    run_op("R3 div", 4'h3, 32'd100, 32'd7, 16'h0, 32'd14);
    run_op("R3 mod", 4'hD, 32'd100, 32'd7, 16'h0, 32'd2);
    run_op("R3 div unsigned", 4'h3, 32'hFFFF_FFFF, 32'd2, 16'h0, 32'h7FFF_FFFF);
    run_op("R3 mod unsigned", 4'hD, 32'h8000_0001, 32'd16, 16'h0, 32'd1);
  endtask

  task automatic t_div_zero;
    run_op("R4 div by zero", 4'h3, 32'd55, 32'd0, 16'h0, 32'hFFFF_FFFF);
    run_op("R4 mod by zero", 4'hD, 32'd0, 32'd0, 16'h0, 32'hFFFF_FFFF);
    run_op("R4 ovf clears", 4'h0, 32'd1, 32'd0, 16'h0, 32'd1);
  endtask

  task automatic t_bitwise;
    run_op("R5 and", 4'h4, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 32'hF000_1200);
    run_op("R5 or", 4'h5, 32'hF0F0_0000, 32'h0F00_000F, 16'h0, 32'hFFF0_000F);
    run_op("R5 xor", 4'h6, 32'hAAAA_AAAA, 32'hFFFF_0000, 16'h0, 32'h5555_AAAA);
    run_op("R5 nand", 4'hA, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'h0);
    run_op("R5 nor", 4'hB, 32'h0000_00F0, 32'h0000_000F, 16'h0, 32'hFFFF_FF00);
    run_op("R5 xnor", 4'hC, 32'h1234_5678, 32'h1234_5678, 16'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_not;
    run_op("R6 not", 4'h7, 32'h0F0F_0000, 32'h0, 16'h0, 32'hF0F0_FFFF);
    run_op("R6 not ignores b", 4'h7, 32'h0F0F_0000, 32'hDEAD_BEEF, 16'h0, 32'hF0F0_FFFF);
  endtask

  task automatic t_shift;
    run_op("R7 shl", 4'h8, 32'h0000_0003, 32'd4, 16'h0, 32'h0000_0030);
    run_op("R7 shl high b ignored", 4'h8, 32'h8000_0001, 32'h21, 16'h0, 32'h0000_0002);
    run_op("R7 shr logical", 4'h9, 32'h8000_0000, 32'hFFFF_FFE4, 16'h0, 32'h0800_0000);
    run_op("R7 shr by 31", 4'h9, 32'hFFFF_FFFF, 32'd31, 16'h0, 32'h1);
  endtask

  task automatic t_imm;
    run_op("R8 addi", 4'hE, 32'h10, 32'hFFFF, 16'hFFFF, 32'h0001_000F);
    run_op("R8 addi wrap", 4'hE, 32'hFFFF_FFFF, 32'h0, 16'h0001, 32'h0);
    run_op("R8 mov zero-extend", 4'hF, 32'hFFFF_FFFF, 32'h1, 16'h8000, 32'h0000_8000);
    run_op("R8 mov zero", 4'hF, 32'h5, 32'h5, 16'h0, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_addsub();
    t_mul();
    t_divmod();
    t_div_zero();
    t_bitwise();
    t_not();
    t_shift();
    t_imm();
    t_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule